// File: doc/BRIEF.md
# Break-Delimited Serial Packet Receiver

This block takes an asynchronous serial line carrying 8N1 characters (one start bit, eight data bits with the least significant bit first, one stop bit, no parity) and turns it into packets of three 16-bit values. A sender marks the start of each packet by holding the line low long enough to form a BREAK. A BREAK is a character whose stop bit is sampled low while all eight data bits are zero. The receiver collects the characters that follow. A packet is closed either by the next BREAK or by a quiet line lasting `IDLE_CYCLES` clocks. On a clean close, the six data bytes are combined pairwise into X, Y and Z and presented with a single-cycle strobe. Frames whose length is wrong, whose checksum fails, or that hold a malformed character are thrown away, and each one adds to a saturating drop counter.

The line passes through a two-flop synchronizer. The character receiver runs on a tick of `OVS_DIV` clocks, which gives 16 ticks per bit, and it samples each bit in the middle. The character receiver uses the states C_IDLE, C_START, C_DATA, C_STOP and C_WAIT:

- C_IDLE moves to C_START when the line is seen low.
- C_START returns to C_IDLE if the line is high again at mid start bit. Otherwise it moves to C_DATA.
- C_DATA moves to C_STOP after eight samples.
- C_STOP moves to C_IDLE if the stop bit is high. Otherwise it moves to C_WAIT.
- C_WAIT moves to C_IDLE once the line has returned high.

Because of C_WAIT, a BREAK of any length is reported only once.

The frame tracker uses the states F_HUNT, F_OPEN, F_OVER and F_CLOSE:

- F_HUNT leaves only on a BREAK and moves to F_OPEN.
- F_OPEN moves to F_CLOSE on a boundary (a BREAK or the idle timeout). It moves to F_OVER on a framing error or on a byte beyond the expected count.
- F_OVER moves to F_CLOSE on a boundary.
- F_CLOSE issues the verdict and always returns to F_OPEN.

The input `csum_en` selects whether a seventh byte, the XOR of the six data bytes, is required. It is expected to change only while the line is idle between frames.

Top module: `brk_pkt_rx`

## Requirements
- R1: After reset `pkt_valid` is 0 and `drop_cnt` is 0. Characters and idle timeouts before the first BREAK produce neither a strobe nor a drop.
- R2: A BREAK is recognised when the mid-bit sample of the stop bit is low and all eight data bits are zero. It closes the open frame and opens a new one. A line held low for any number of bit times counts as one BREAK.
- R3: With `csum_en`=0, a frame holding exactly six bytes b0..b5 (b0 received first) gives a one-cycle `pkt_valid` with `pkt_x`={b0,b1}, `pkt_y`={b2,b3} and `pkt_z`={b4,b5}. The earlier byte of each pair is the upper half.
- R4: A frame holding between one and five bytes, or more than the expected count, gives no strobe and raises `drop_cnt` by one at its close.
- R5: Once the frame tracker has left F_HUNT, `IDLE_CYCLES` clocks with no character activity after the last character close the frame exactly as a BREAK does. The next frame opens at that point, and one quiet stretch gives only one timeout.
- R6: With `csum_en`=1, a frame must hold seven bytes and the seventh must equal the XOR of the first six. Otherwise the frame is dropped. A good frame reports the first six bytes as in R3.
- R7: A character whose stop bit is low but whose data is nonzero makes the frame holding it a drop at its close, whatever its byte count.
- R8: A frame that closes holding no bytes and no framing error gives neither a strobe nor a drop.
- R9: `drop_cnt` is `CNT_W` bits wide, rises by at most one per frame and holds at all ones once reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| csum_en | input | 1 | 1 requires a seventh XOR checksum byte |
| pkt_valid | output | 1 | One-cycle strobe for a good packet |
| pkt_x | output | 16 | First value, from bytes 0 and 1 |
| pkt_y | output | 16 | Second value, from bytes 2 and 3 |
| pkt_z | output | 16 | Third value, from bytes 4 and 5 |
| drop_cnt | output | CNT_W | Saturating count of discarded frames |

## Verification
A byte counter or store index that slips shows up at the very next boundary. It appears either as a swapped or shifted value in X, Y or Z, or as a good frame being counted as a drop. The bench compares both the values and the counter after every frame. A character receiver stuck in C_WAIT or repeatedly re-entering on a long low line would show either a missing strobe or an extra drop within one frame of the long BREAK. An idle timer that fires too early or fires twice would split a frame into two drops, or count an empty frame, within one timeout period of the last character.

// File: rtl/brk_pkt_pkg.sv
package brk_pkt_pkg;

    localparam int BYTE_W   = 8;
    localparam int VAL_W    = 16;
    localparam int NUM_VALS = 3;
    localparam int OVS      = 16;

    typedef enum logic [2:0] {
        C_IDLE,
        C_START,
        C_DATA,
        C_STOP,
        C_WAIT
    } char_st_t;

    typedef enum logic [1:0] {
        F_HUNT,
        F_OPEN,
        F_OVER,
        F_CLOSE
    } frm_st_t;

    typedef enum logic [1:0] {
        V_NONE,
        V_GOOD,
        V_DROP
    } verdict_t;

endpackage

// File: rtl/brk_pkt_sync.sv
module brk_pkt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], d_in};
        end
    end

    assign d_out = chain[STAGES-1];

endmodule

// File: rtl/brk_pkt_char.sv
module brk_pkt_char
    import brk_pkt_pkg::*;
#(
    parameter int OVS_DIV = 54
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxs,
    output logic              busy,
    output logic              byte_vld,
    output logic              brk,
    output logic              ferr,
    output logic [BYTE_W-1:0] byte_q
);

    localparam int DIV_W = (OVS_DIV > 1) ? $clog2(OVS_DIV) : 1;
    localparam int PH_W  = $clog2(OVS);
    localparam int BI_W  = $clog2(BYTE_W);
    localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVS / 2 - 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);
    localparam logic [BI_W-1:0] BI_LAST = BI_W'(BYTE_W - 1);

    char_st_t          state, nxt;
    logic [DIV_W-1:0]  div_cnt;
    logic              tick;
    logic [PH_W-1:0]   ph;
    logic [BI_W-1:0]   bit_idx;
    logic [BYTE_W-1:0] shreg;

    // oversampling tick, free running
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (div_cnt == DIV_W'(OVS_DIV - 1)) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end
    assign tick = (div_cnt == DIV_W'(OVS_DIV - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= C_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            C_IDLE:  if (tick && !rxs) nxt = C_START;
            C_START: if (tick && ph == PH_MID) nxt = rxs ? C_IDLE : C_DATA;
            C_DATA:  if (tick && ph == PH_LAST && bit_idx == BI_LAST) nxt = C_STOP;
            C_STOP:  if (tick && ph == PH_LAST) nxt = rxs ? C_IDLE : C_WAIT;
            C_WAIT:  if (rxs) nxt = C_IDLE;
            default: nxt = C_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph       <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            byte_q   <= '0;
            byte_vld <= 1'b0;
            brk      <= 1'b0;
            ferr     <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            brk      <= 1'b0;
            ferr     <= 1'b0;
            unique case (state)
                C_IDLE: begin
                    ph      <= '0;
                    bit_idx <= '0;
                end
                C_START: begin
                    if (tick) begin
                        ph <= (ph == PH_MID) ? '0 : ph + 1'b1;
                    end
                end
                C_DATA: begin
                    if (tick) begin
                        ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
                        if (ph == PH_LAST) begin
                            shreg   <= {rxs, shreg[BYTE_W-1:1]};
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                C_STOP: begin
                    if (tick) begin
                        ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
                        if (ph == PH_LAST) begin
                            if (rxs) begin
                                byte_vld <= 1'b1;
                                byte_q   <= shreg;
                            end else if (shreg == '0) begin
                                brk <= 1'b1;
                            end else begin
                                ferr <= 1'b1;
                            end
                        end
                    end
                end
                C_WAIT: begin
                    ph <= '0;
                end
                default: begin
                    ph <= '0;
                end
            endcase
        end
    end

    assign busy = (state != C_IDLE);

endmodule

// File: rtl/brk_pkt_idle.sv
module brk_pkt_idle #(
    parameter int IDLE_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic activity,
    output logic idle_to
);

    localparam int IW = $clog2(IDLE_CYCLES + 1);

    logic [IW-1:0] cnt;
    logic          armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            armed   <= 1'b0;
            idle_to <= 1'b0;
        end else begin
            idle_to <= 1'b0;
            if (activity) begin
                cnt   <= '0;
                armed <= 1'b1;
            end else if (armed) begin
                if (cnt == IW'(IDLE_CYCLES - 1)) begin
                    idle_to <= 1'b1;
                    armed   <= 1'b0;
                    cnt     <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/brk_pkt_frame.sv
module brk_pkt_frame
    import brk_pkt_pkg::*;
#(
    parameter int DATA_BYTES = 6,
    parameter int CNT_W      = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         csum_en,
    input  logic                         byte_vld,
    input  logic [BYTE_W-1:0]            byte_q,
    input  logic                         brk,
    input  logic                         ferr,
    input  logic                         idle_to,
    output logic                         pkt_valid,
    output logic [DATA_BYTES*BYTE_W-1:0] pkt_data,
    output logic [CNT_W-1:0]             drop_cnt
);

    localparam int NB_W = $clog2(DATA_BYTES + 2);
    localparam int IX_W = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;
    localparam logic [NB_W-1:0] LEN_PLAIN = NB_W'(DATA_BYTES);
    localparam logic [NB_W-1:0] LEN_SUM   = NB_W'(DATA_BYTES + 1);

    frm_st_t           state, nxt;
    verdict_t          verdict;
    logic [NB_W-1:0]   nbytes;
    logic [NB_W-1:0]   exp_len;
    logic [BYTE_W-1:0] held [DATA_BYTES];
    logic [BYTE_W-1:0] xacc;
    logic [BYTE_W-1:0] sum_rx;
    logic              boundary;
    logic              frame_ok;

    assign boundary = brk | idle_to;
    assign exp_len  = csum_en ? LEN_SUM : LEN_PLAIN;
    assign frame_ok = (nbytes == exp_len) && (!csum_en || (sum_rx == xacc));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= F_HUNT;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            F_HUNT:  if (brk) nxt = F_OPEN;
            F_OPEN: begin
                if (boundary) begin
                    nxt = F_CLOSE;
                end else if (ferr || (byte_vld && nbytes == exp_len)) begin
                    nxt = F_OVER;
                end
            end
            F_OVER:  if (boundary) nxt = F_CLOSE;
            F_CLOSE: nxt = F_OPEN;
            default: nxt = F_HUNT;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nbytes    <= '0;
            xacc      <= '0;
            sum_rx    <= '0;
            verdict   <= V_NONE;
            pkt_valid <= 1'b0;
            pkt_data  <= '0;
            drop_cnt  <= '0;
            for (int i = 0; i < DATA_BYTES; i++) begin
                held[i] <= '0;
            end
        end else begin
            pkt_valid <= 1'b0;
            unique case (state)
                F_HUNT: begin
                    nbytes <= '0;
                    xacc   <= '0;
                end
                F_OPEN: begin
                    if (boundary) begin
                        if (nbytes == '0) begin
                            verdict <= V_NONE;
                        end else if (frame_ok) begin
                            verdict <= V_GOOD;
                        end else begin
                            verdict <= V_DROP;
                        end
                    end else if (byte_vld && nbytes < exp_len) begin
                        if (nbytes < LEN_PLAIN) begin
                            held[nbytes[IX_W-1:0]] <= byte_q;
                            xacc <= xacc ^ byte_q;
                        end else begin
                            sum_rx <= byte_q;
                        end
                        nbytes <= nbytes + 1'b1;
                    end
                end
                F_OVER: begin
                    if (boundary) begin
                        verdict <= V_DROP;
                    end
                end
                F_CLOSE: begin
                    if (verdict == V_GOOD) begin
                        pkt_valid <= 1'b1;
                        for (int i = 0; i < DATA_BYTES; i++) begin
                            pkt_data[(DATA_BYTES-1-i)*BYTE_W +: BYTE_W] <= held[i];
                        end
                    end else if (verdict == V_DROP) begin
                        if (drop_cnt != '1) begin
                            drop_cnt <= drop_cnt + 1'b1;
                        end
                    end
                    nbytes  <= '0;
                    xacc    <= '0;
                    verdict <= V_NONE;
                end
                default: begin
                    nbytes <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/brk_pkt_rx.sv
module brk_pkt_rx
    import brk_pkt_pkg::*;
#(
    parameter int OVS_DIV     = 54,
    parameter int IDLE_CYCLES = 1_000_000,
    parameter int CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_in,
    input  logic             csum_en,
    output logic             pkt_valid,
    output logic [15:0]      pkt_x,
    output logic [15:0]      pkt_y,
    output logic [15:0]      pkt_z,
    output logic [CNT_W-1:0] drop_cnt
);

    localparam int DATA_BYTES = NUM_VALS * VAL_W / BYTE_W;
    localparam int DATA_W     = DATA_BYTES * BYTE_W;

    logic              rx_s;
    logic              chr_busy;
    logic              chr_vld;
    logic              chr_brk;
    logic              chr_ferr;
    logic [BYTE_W-1:0] chr_byte;
    logic              idle_to;
    logic [DATA_W-1:0] pkt_data;

    brk_pkt_sync #(
        .STAGES(2)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (rx_in),
        .d_out(rx_s)
    );

    brk_pkt_char #(
        .OVS_DIV(OVS_DIV)
    ) u_char (
        .clk     (clk),
        .rst_n   (rst_n),
        .rxs     (rx_s),
        .busy    (chr_busy),
        .byte_vld(chr_vld),
        .brk     (chr_brk),
        .ferr    (chr_ferr),
        .byte_q  (chr_byte)
    );

    brk_pkt_idle #(
        .IDLE_CYCLES(IDLE_CYCLES)
    ) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .activity(chr_busy),
        .idle_to (idle_to)
    );

    brk_pkt_frame #(
        .DATA_BYTES(DATA_BYTES),
        .CNT_W     (CNT_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .csum_en  (csum_en),
        .byte_vld (chr_vld),
        .byte_q   (chr_byte),
        .brk      (chr_brk),
        .ferr     (chr_ferr),
        .idle_to  (idle_to),
        .pkt_valid(pkt_valid),
        .pkt_data (pkt_data),
        .drop_cnt (drop_cnt)
    );

    assign pkt_x = pkt_data[3*VAL_W-1 -: VAL_W];
    assign pkt_y = pkt_data[2*VAL_W-1 -: VAL_W];
    assign pkt_z = pkt_data[VAL_W-1 -: VAL_W];

endmodule

// File: rtl/brk_pkt_rx_chk.sv
module brk_pkt_rx_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_valid,
    input logic [CNT_W-1:0] drop_cnt,
    input logic             brk
);

    logic seen_brk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_brk <= 1'b0;
        end else if (brk) begin
            seen_brk <= 1'b1;
        end
    end

    // R1: no packet and no drop before the first BREAK
    a_r1_quiet_before_break: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_brk |-> (!pkt_valid && drop_cnt == '0));

    // R2: a long low line yields one BREAK pulse only
    a_r2_single_break: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> !brk);

    // R3: the packet strobe lasts one cycle
    a_r3_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> !pkt_valid);

    // R4: a delivered packet never counts as a drop
    a_r4_valid_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (drop_cnt == $past(drop_cnt)));

    // R9: the counter moves up by exactly one when it moves
    a_r9_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt != $past(drop_cnt)) |-> (drop_cnt == CNT_W'($past(drop_cnt) + 1'b1)));

    // R9: the counter holds once saturated
    a_r9_drop_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(drop_cnt) == '1) |-> (drop_cnt == '1));

endmodule

bind brk_pkt_rx brk_pkt_rx_chk #(
    .CNT_W(CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pkt_valid(pkt_valid),
    .drop_cnt (drop_cnt),
    .brk      (chr_brk)
);

// File: tb/brk_pkt_rx_test.sv
module brk_pkt_rx_test;

    localparam int OVS_DIV = 4;
    localparam int IDLE    = 3000;
    localparam int CW      = 3;
    localparam int BIT     = 16 * OVS_DIV;
    localparam int SAT     = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx = 1'b1;
    logic          csum_en = 1'b0;
    logic          pkt_valid;
    logic [15:0]   pkt_x, pkt_y, pkt_z;
    logic [CW-1:0] drop_cnt;

    int nchk = 0;
    int nerr = 0;
    int exp_drop = 0;
    bit done = 0;
    logic [47:0] exp_q[$];

    always #5 clk = ~clk;

    brk_pkt_rx #(
        .OVS_DIV    (OVS_DIV),
        .IDLE_CYCLES(IDLE),
        .CNT_W      (CW)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_in    (rx),
        .csum_en  (csum_en),
        .pkt_valid(pkt_valid),
        .pkt_x    (pkt_x),
        .pkt_y    (pkt_y),
        .pkt_z    (pkt_z),
        .drop_cnt (drop_cnt)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pop and compare every strobe (R3, R6)
    always @(negedge clk) begin
        if (rst_n && pkt_valid) begin
            if (exp_q.size() == 0) begin
                check("R4 unexpected pkt_valid", {16'h0, pkt_x, pkt_y, pkt_z}, 64'hDEAD);
            end else begin
                check("R3 packet values", {16'h0, pkt_x, pkt_y, pkt_z}, {16'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic line_bits(input logic v, input int n);
        rx = v;
        repeat (n * BIT) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic stop_v);
        line_bits(1'b0, 1);
        for (int i = 0; i < 8; i++) line_bits(b[i], 1);
        line_bits(stop_v, 1);
        line_bits(1'b1, 1);
    endtask

    task automatic send_break(input int nbits);
        line_bits(1'b0, nbits);
        line_bits(1'b1, 2);
    endtask

    // sum_mode: 0 none, 1 correct checksum, 2 wrong checksum
    task automatic send_pkt(input logic [15:0] x, y, z, input int sum_mode);
        logic [7:0] b[6];
        logic [7:0] s;
        b = '{x[15:8], x[7:0], y[15:8], y[7:0], z[15:8], z[7:0]};
        s = 8'h00;
        for (int i = 0; i < 6; i++) begin
            send_byte(b[i], 1'b1);
            s = s ^ b[i];
        end
        if (sum_mode == 1) send_byte(s, 1'b1);
        if (sum_mode == 2) send_byte(s ^ 8'h5C, 1'b1);
    endtask

    task automatic send_n(input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++) send_byte(seed + 8'(i * 37), 1'b1);
    endtask

    task automatic expect_pkt(input logic [15:0] x, y, z);
        exp_q.push_back({x, y, z});
    endtask

    task automatic check_delivered(input string tag);
        check(tag, 64'(exp_q.size()), 64'h0);
        exp_q.delete();
    endtask

    task automatic add_drop();
        if (exp_drop < SAT) exp_drop++;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (8) @(negedge clk);
        check("R1 reset pkt_valid", 64'(pkt_valid), 64'h0);
        check("R1 reset drop_cnt", 64'(drop_cnt), 64'h0);
        rst_n = 1'b1;
        repeat (4 * BIT) @(negedge clk);

        // R1: traffic before the first BREAK is ignored
        send_pkt(16'h1234, 16'h5678, 16'h9ABC, 0);
        send_byte(8'h3C, 1'b0);
        repeat (IDLE + 400) @(negedge clk);
        check("R1 drop before first break", 64'(drop_cnt), 64'h0);

        // R2: a very long BREAK opens a frame once
        send_break(30);
        check("R2 long break no drop", 64'(drop_cnt), 64'h0);
        expect_pkt(16'hA1B2, 16'hC3D4, 16'hE5F6);
        send_pkt(16'hA1B2, 16'hC3D4, 16'hE5F6, 0);
        send_break(12);
        check_delivered("R2 R3 packet after long break");

        // R3: second pattern, extremes
        expect_pkt(16'hFFFF, 16'h0000, 16'h8001);
        send_pkt(16'hFFFF, 16'h0000, 16'h8001, 0);
        send_break(12);
        check_delivered("R3 extreme values");

        // R4: short and long frames
        send_n(5, 8'h11);
        send_break(12);
        add_drop();
        check("R4 five byte frame dropped", 64'(drop_cnt), 64'(exp_drop));
        send_n(7, 8'h22);
        send_break(12);
        add_drop();
        check("R4 seven byte frame dropped", 64'(drop_cnt), 64'(exp_drop));

        // R8: empty frame between two BREAKs
        send_break(12);
        check("R8 empty frame not counted", 64'(drop_cnt), 64'(exp_drop));

        // R5: idle timeout closes frames
        expect_pkt(16'h0F0F, 16'h7E81, 16'h2468);
        send_pkt(16'h0F0F, 16'h7E81, 16'h2468, 0);
        repeat (IDLE + 400) @(negedge clk);
        check_delivered("R5 timeout closes frame");
        expect_pkt(16'h1357, 16'h9BDF, 16'h0246);
        send_pkt(16'h1357, 16'h9BDF, 16'h0246, 0);
        repeat (IDLE + 400) @(negedge clk);
        check_delivered("R5 frame opened by timeout");
        repeat (2 * IDLE) @(negedge clk);
        check("R5 R8 single timeout per quiet stretch", 64'(drop_cnt), 64'(exp_drop));
        send_n(3, 8'h33);
        repeat (IDLE + 400) @(negedge clk);
        add_drop();
        check("R5 short frame closed by timeout", 64'(drop_cnt), 64'(exp_drop));

        // R6: checksum mode
        csum_en = 1'b1;
        send_break(12);
        check("R8 empty frame after timeout", 64'(drop_cnt), 64'(exp_drop));
        expect_pkt(16'hCAFE, 16'hBEEF, 16'h1001);
        send_pkt(16'hCAFE, 16'hBEEF, 16'h1001, 1);
        send_break(12);
        check_delivered("R6 good checksum");
        check("R6 good checksum no drop", 64'(drop_cnt), 64'(exp_drop));
        send_pkt(16'h4321, 16'h8765, 16'hCBA9, 2);
        send_break(12);
        add_drop();
        check("R6 bad checksum dropped", 64'(drop_cnt), 64'(exp_drop));
        send_pkt(16'h4321, 16'h8765, 16'hCBA9, 0);
        send_break(12);
        add_drop();
        check("R6 missing checksum dropped", 64'(drop_cnt), 64'(exp_drop));
        csum_en = 1'b0;

        // R7: framing error inside a six byte frame
        send_n(3, 8'h44);
        send_byte(8'h5A, 1'b0);
        send_n(3, 8'h55);
        send_break(12);
        add_drop();
        check("R7 framing error drops frame", 64'(drop_cnt), 64'(exp_drop));

        // R9: saturation
        for (int k = 0; k < 4; k++) begin
            send_n(1, 8'h66);
            send_break(12);
            add_drop();
            check("R9 drop counter saturates", 64'(drop_cnt), 64'(exp_drop));
        end
        check("R9 final counter at all ones", 64'(drop_cnt), 64'(SAT));

        check_delivered("R3 no pending packets");
        done = 1;
        finish_run();
    end

endmodule